// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits in the decode stage of a five-stage in-order pipeline. It holds the decode-to-execute control register. Each cycle it compares the destination of a load now in execute with the two source-register fields of the instruction being decoded. A load writes its register only after the memory access. If the decoding instruction reads that register, forwarding cannot supply the value in time, so the block raises a one-cycle stall.

During a stall, the program-counter write enable and the fetch/decode register write enable go low, so the fetch stage and the decode stage hold their contents. At the same edge the control word written into the execute register is forced to zero. This sends an empty slot down the pipe. On the next cycle the load has moved on to the memory stage, and forwarding covers the dependence. The stall therefore never lasts longer than one cycle.

Top module: `loaduse_stall_unit`

## Requirements
- R1: `stall_bubble` is high, in the same cycle, exactly when three things hold together: bit 0 of `ex_ctrl` (the memory-read flag) is 1, `ex_dst` is non-zero, and `ex_dst` equals `dec_src_a` or `dec_src_b`.
- R2: `pc_we` is the inverse of the stall condition. It is low in every stall cycle and high in every other cycle.
- R3: `ifid_we` is low in every stall cycle and high in every other cycle.
- R4: At a rising edge with no reset, `ex_ctrl` loads all zeros if the stall condition held in that cycle, and loads `dec_ctrl` otherwise. `ex_dst` always loads `dec_dst`.
- R5: If bit 0 of `ex_ctrl` is 0, there is no stall, even when `ex_dst` matches a source field.
- R6: If `ex_dst` is register 0, there is no stall, whatever the control word and the source fields.
- R7: While the decode inputs are held, a load followed directly by a consumer of its destination produces exactly one stall cycle. A consumer two or more instructions after the load produces none.
- R8: A synchronous active-high `rst` clears `ex_ctrl` to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_src_a | input | REG_W | First source register field of the decoding instruction |
| dec_src_b | input | REG_W | Second source register field of the decoding instruction |
| dec_dst | input | REG_W | Load destination field of the decoding instruction |
| dec_ctrl | input | CTRL_W | Decoded control word; bit 0 is the memory-read flag |
| ex_ctrl | output | CTRL_W | Control word held in the execute stage |
| ex_dst | output | REG_W | Load destination field held in the execute stage |
| stall_bubble | output | 1 | High in a stall cycle; zeroes the next control word |
| pc_we | output | 1 | Program-counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |

## Verification
The only state is the execute-stage control word and destination field. A wrong value there shows at the ports in the same cycle, as a missing or spurious stall on the next decode compare.

A bubble that fails to zero the memory-read flag would show as a second stall cycle immediately after the first. A comparison that ignores register zero, or ignores the memory-read flag, would stall on sequences that must run freely.

The stimulus uses small register indices so that matches are frequent. It holds the decode inputs during a stall, as a frozen decode register would.

// File: rtl/loaduse_stall_unit.sv
module loaduse_stall_unit #(
  parameter int REG_W     = 5,
  parameter int CTRL_W    = 8,
  parameter int MEMRD_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic [REG_W-1:0]  dec_dst,
  input  logic [CTRL_W-1:0] dec_ctrl,
  output logic [CTRL_W-1:0] ex_ctrl,
  output logic [REG_W-1:0]  ex_dst,
  output logic              stall_bubble,
  output logic              pc_we,
  output logic              ifid_we
);

  localparam logic [REG_W-1:0]  ZERO_REG  = '0;
  localparam logic [CTRL_W-1:0] NOP_CTRL  = '0;

  logic ex_is_load;
  logic hit_a, hit_b;

  assign ex_is_load   = ex_ctrl[MEMRD_BIT];
  assign hit_a        = (ex_dst == dec_src_a);
  assign hit_b        = (ex_dst == dec_src_b);
  assign stall_bubble = ex_is_load && (ex_dst != ZERO_REG) && (hit_a || hit_b);
  assign pc_we        = !stall_bubble;
  assign ifid_we      = !stall_bubble;

  always_ff @(posedge clk) begin
    if (rst)               ex_ctrl <= NOP_CTRL;
    else if (stall_bubble) ex_ctrl <= NOP_CTRL;
    else                   ex_ctrl <= dec_ctrl;
    ex_dst <= dec_dst;
  end

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (rst)
    stall_bubble |=> !stall_bubble); // R7
  AST_BUBBLE_ZEROES: assert property (@(posedge clk) disable iff (rst)
    stall_bubble |=> (ex_ctrl == NOP_CTRL)); // R4
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !stall_bubble |=> (ex_ctrl == $past(dec_ctrl))); // R4
  AST_NON_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl[MEMRD_BIT] |-> !stall_bubble); // R5
  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (rst)
    (ex_dst == ZERO_REG) |-> !stall_bubble); // R6
  AST_FREEZE_BOTH: assert property (@(posedge clk) disable iff (rst)
    stall_bubble |-> (!pc_we && !ifid_we)); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (ex_ctrl == NOP_CTRL)); // R8

endmodule

// File: tb/loaduse_stall_unit_bench.sv
module loaduse_stall_unit_bench;
  localparam int RW = 5;
  localparam int CW = 8;

  logic clk = 0;
  logic rst = 1;
  logic [RW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic [CW-1:0] ctrl = '0;
  logic [CW-1:0] ex_ctrl;
  logic [RW-1:0] ex_dst;
  logic stall_bubble, pc_we, ifid_we;

  int checks = 0, failures = 0, run_len = 0;
  logic [CW-1:0] m_ctrl = '0;
  logic [RW-1:0] m_dst = '0;
  bit done = 0;

  always #5 clk = ~clk;

  loaduse_stall_unit u_loaduse_stall_unit (
    .clk(clk), .rst(rst), .dec_src_a(src_a), .dec_src_b(src_b),
    .dec_dst(dst), .dec_ctrl(ctrl), .ex_ctrl(ex_ctrl), .ex_dst(ex_dst),
    .stall_bubble(stall_bubble), .pc_we(pc_we), .ifid_we(ifid_we));

  function automatic bit exp_stall(logic [CW-1:0] c, logic [RW-1:0] d,
                                   logic [RW-1:0] a, logic [RW-1:0] b);
    return c[0] && (d != 0) && (d == a || d == b);
  endfunction

  function automatic string stall_tag(logic [CW-1:0] c, logic [RW-1:0] d);
    if (!c[0]) return "R5";
    if (d == 0) return "R6";
    return "R1";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic [RW-1:0] a, logic [RW-1:0] b,
                     logic [RW-1:0] d, logic [CW-1:0] c, bit r);
    bit s;
    src_a = a; src_b = b; dst = d; ctrl = c; rst = r;
    #1;
    s = exp_stall(m_ctrl, m_dst, a, b);
    if (!r) begin
      chk(stall_tag(m_ctrl, m_dst), stall_bubble, s);
      chk("R2", pc_we, !s);
      chk("R3", ifid_we, !s);
      run_len = stall_bubble ? run_len + 1 : 0;
      if (run_len > 1) chk("R7", run_len, 1);
    end
    @(posedge clk);
    m_ctrl = r ? '0 : (s ? '0 : c);
    m_dst  = d;
    @(negedge clk);
    #1;
    chk(r ? "R8" : "R4", ex_ctrl, m_ctrl);
    chk("R4", ex_dst, m_dst);
  endtask

  function automatic bit will_stall(logic [RW-1:0] a, logic [RW-1:0] b);
    return exp_stall(m_ctrl, m_dst, a, b);
  endfunction

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    cyc(0, 0, 0, 8'h00, 1);
    cyc(0, 0, 0, 8'h00, 1);
    chk("R8", ex_ctrl, 0);
    // R1, R7: load r3 then consumer on src_a: one stall, then held instr passes
    cyc(1, 2, 3, 8'h05, 0);
    cyc(3, 4, 6, 8'h02, 0);
    cyc(3, 4, 6, 8'h02, 0);
    // R1: consumer on src_b
    cyc(1, 2, 7, 8'h01, 0);
    cyc(5, 7, 9, 8'h02, 0);
    cyc(5, 7, 9, 8'h02, 0);
    // R6: load to r0, consumer of r0
    cyc(1, 2, 0, 8'h01, 0);
    cyc(0, 0, 4, 8'h02, 0);
    // R5: non-load producer of r4 then consumer
    cyc(1, 2, 4, 8'h02, 0);
    cyc(4, 4, 5, 8'h02, 0);
    // R7: load r8, unrelated, then consumer two later: no stall
    cyc(1, 2, 8, 8'h01, 0);
    cyc(9, 10, 11, 8'h02, 0);
    cyc(8, 8, 12, 8'h02, 0);
    // R8: reset in the middle of a load
    cyc(1, 2, 3, 8'h01, 1);
    cyc(3, 3, 1, 8'h02, 0);
    for (int i = 0; i < 400; i++) begin
      logic [RW-1:0] a, b, d;
      logic [CW-1:0] c;
      a = RW'($urandom_range(0, 3));
      b = RW'($urandom_range(0, 3));
      d = RW'($urandom_range(0, 3));
      c = CW'($urandom);
      if (i == 200) begin
        cyc(a, b, d, c, 1);
      end else if (will_stall(a, b)) begin
        cyc(a, b, d, c, 0);
        cyc(a, b, d, c, 0);
      end else begin
        cyc(a, b, d, c, 0);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule